// File: doc/BRIEF.md
# Decimal-Digit Sequential Divider

This block divides a 10-bit unsigned dividend by a 10-bit unsigned divisor. It builds the quotient one decimal digit at a time rather than one binary bit at a time. A one-cycle start pulse, taken while the block is idle, loads both operands.

The block first multiplies the divisor by ten again and again, using only shifts and an adder, until one more step would exceed the dividend. It then subtracts the largest scaled divisor, one subtraction per clock, and counts the subtractions to get the leading decimal digit. After that it steps down one decimal place and counts the next digit. Each finished digit is folded into a binary quotient as quotient times ten plus the digit. When the unscaled divisor can no longer be subtracted, the value left over is the remainder.

A zero divisor, or a dividend smaller than the divisor, skips the scaling and the counting. The outputs then appear after one clock. Results stay on the outputs until the next accepted start. All registers clear on an asynchronous active-low reset.

Top module: `decdiv`

## Requirements
- R1: For a nonzero divisor, after done the quotient output equals floor(dividend / divisor) and the remainder output equals dividend mod divisor, both 10-bit unsigned.
- R2: When the dividend is at least the divisor, done rises 2k + 3 + S rising edges after the edge that samples start (that edge counted as 1). Here k is the number of times the divisor can be multiplied by ten without exceeding the dividend, and S is the sum of the decimal digits of the quotient. This corresponds to one subtraction per clock. For example, 128 / 4 uses five subtractions and completes on edge 10.
- R3: A zero divisor sets the divide-by-zero output and gives quotient 0 and remainder equal to the dividend, with done on edge 1.
- R4: A dividend smaller than a nonzero divisor gives quotient 0, remainder equal to the dividend and divide-by-zero low, with done on edge 1.
- R5: Done is high for exactly one clock per accepted start.
- R6: A start pulse during a division is ignored: the running result and its latency do not change.
- R7: Quotient, remainder and divide-by-zero hold their values from one done until the next done.
- R8: While reset is low, all outputs read zero at once, without waiting for a clock edge.
- R9: Divide-by-zero falls on the done of the next division that has a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| dividend_i | input | 10 | Unsigned dividend |
| divisor_i | input | 10 | Unsigned divisor |
| quotient_o | output | 10 | Binary quotient |
| remainder_o | output | 10 | Remainder |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Set when the last division had a zero divisor |

## Verification
The operand pairs are chosen to separate the different routes through the block:
- Quotients with many digits, or with zero digits in the middle (999 / 1, 1000 / 1, 500 / 7, 128 / 4), show whether digit counts are folded correctly and whether a zero digit still passes through its own decimal place.
- Equal operands and the all-ones corners check the boundary of the scaling compare.
- Latency is compared against the digit-sum formula, which exposes a missed or extra subtraction even when the final value happens to be right.
- Directed cases cover a zero divisor, a dividend below the divisor, a start during a division, and a reset in the middle of a division.

// File: rtl/decdiv_pkg.sv
// Shared types and constant helpers for the decimal-digit divider.
// Assumes operand widths of at most 30 bits.
package decdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCALE,
        ST_COUNT
    } dd_state_e;

    // Number of decimal digits in the largest unsigned value of w bits.
    function automatic int dd_dec_digits(input int w);
        longint v;
        int     n;
        v = (longint'(1) << w) - 1;
        n = 0;
        while (v > 0) begin
            v = v / 10;
            n = n + 1;
        end
        return n;
    endfunction

endpackage

// File: rtl/decdiv_times10.sv
// Multiplies by ten using two shifts and one adder, with no multiplier.
// Assumes the caller has sized W so that the product fits.
module decdiv_times10 #(
    parameter int W = 14
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] y_i10_o
);
    // Product is eight times a plus two times a.
    assign y_i10_o = (a_i << 3) + (a_i << 1);
endmodule

// File: rtl/decdiv_step.sv
// One trial subtraction: it reports whether the scaled divisor fits into the
// partial remainder and gives the difference.
// The difference is meaningful only when fits_o is high.
module decdiv_step #(
    parameter int W = 14
) (
    input  logic [W-1:0] part_i,
    input  logic [W-1:0] scaled_i,
    output logic         fits_o,
    output logic [W-1:0] diff_o
);
    // Compare and subtract side by side.
    assign fits_o = (part_i >= scaled_i);
    assign diff_o = part_i - scaled_i;
endmodule

// File: rtl/decdiv_ladder.sv
// Holds the divisor scaled by 10^0 up to 10^(DEPTH-1), so stepping down a
// decimal place is a read and needs no divide-by-ten.
// Assumes at most one rung is written per cycle.
module decdiv_ladder #(
    parameter int W     = 14,
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [W-1:0]     wr_val_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [W-1:0]     rd_val_o
);
    logic [W-1:0] rung [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rung
        logic [W-1:0] val_q;
        // Load this rung when it is addressed.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                val_q <= wr_val_i;
            end
        end
        assign rung[g] = val_q;
    end

    // Read port, with an out-of-range index giving zero.
    assign rd_val_o = (int'(rd_idx_i) < DEPTH) ? rung[rd_idx_i] : '0;
endmodule

// File: rtl/decdiv.sv
// Sequential unsigned divider that finds one decimal quotient digit per
// decimal place by repeated subtraction of a power-of-ten scaled divisor.
// Assumes start is a pulse; operands are sampled only when idle.
module decdiv
    import decdiv_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] dividend_i,
    input  logic [DATA_W-1:0] divisor_i,
    output logic [DATA_W-1:0] quotient_o,
    output logic [DATA_W-1:0] remainder_o,
    output logic              done_o,
    output logic              div_zero_o
);
    localparam int DIGITS = dd_dec_digits(DATA_W);
    localparam int INT_W  = DATA_W + 4;
    localparam int LVL_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1;
    localparam int DIG_W  = 4;

    dd_state_e         state_q;
    logic [INT_W-1:0]  part_q;
    logic [INT_W-1:0]  scaled_q;
    logic [INT_W-1:0]  quo_acc_q;
    logic [LVL_W-1:0]  level_q;
    logic [DIG_W-1:0]  digit_q;

    logic [INT_W-1:0]  scale_y;
    logic [INT_W-1:0]  fold_y;
    logic [INT_W-1:0]  new_quo;
    logic [INT_W-1:0]  diff;
    logic              fits;
    logic              scale_stop;
    logic              busy;
    logic              lad_wr_en;
    logic [LVL_W-1:0]  lad_wr_idx;
    logic [INT_W-1:0]  lad_wr_val;
    logic [LVL_W-1:0]  lad_rd_idx;
    logic [INT_W-1:0]  lad_rd_val;

    decdiv_times10 #(.W(INT_W)) u_scale (.a_i(scaled_q),  .y_i10_o(scale_y));
    decdiv_times10 #(.W(INT_W)) u_fold  (.a_i(quo_acc_q), .y_i10_o(fold_y));

    decdiv_step #(.W(INT_W)) u_step (
        .part_i  (part_q),
        .scaled_i(scaled_q),
        .fits_o  (fits),
        .diff_o  (diff)
    );

    decdiv_ladder #(.W(INT_W), .DEPTH(DIGITS), .IDX_W(LVL_W)) u_ladder (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (lad_wr_en),
        .wr_idx_i(lad_wr_idx),
        .wr_val_i(lad_wr_val),
        .rd_idx_i(lad_rd_idx),
        .rd_val_o(lad_rd_val)
    );

    // Scaling ends when the next power of ten would pass the dividend.
    assign scale_stop = (scale_y > part_q) || (level_q == LVL_W'(DIGITS - 1));
    // Running quotient times ten plus the digit just counted.
    assign new_quo    = fold_y + INT_W'(digit_q);
    assign busy       = (state_q != ST_IDLE);
    assign lad_rd_idx = LVL_W'(level_q - 1'b1);

    // Select which ladder rung is written this cycle.
    always_comb begin
        lad_wr_en  = 1'b0;
        lad_wr_idx = '0;
        lad_wr_val = scale_y;
        if (state_q == ST_IDLE && start_i && divisor_i != '0 && dividend_i >= divisor_i) begin
            lad_wr_en  = 1'b1;
            lad_wr_val = INT_W'(divisor_i);
        end else if (state_q == ST_SCALE && !scale_stop) begin
            lad_wr_en  = 1'b1;
            lad_wr_idx = LVL_W'(level_q + 1'b1);
        end
    end

    // Sequencer, datapath registers and result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            part_q      <= '0;
            scaled_q    <= '0;
            quo_acc_q   <= '0;
            level_q     <= '0;
            digit_q     <= '0;
            quotient_o  <= '0;
            remainder_o <= '0;
            done_o      <= 1'b0;
            div_zero_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (divisor_i == '0) begin
                            quotient_o  <= '0;
                            remainder_o <= dividend_i;
                            div_zero_o  <= 1'b1;
                            done_o      <= 1'b1;
                        end else if (dividend_i < divisor_i) begin
                            quotient_o  <= '0;
                            remainder_o <= dividend_i;
                            div_zero_o  <= 1'b0;
                            done_o      <= 1'b1;
                        end else begin
                            part_q    <= INT_W'(dividend_i);
                            scaled_q  <= INT_W'(divisor_i);
                            quo_acc_q <= '0;
                            level_q   <= '0;
                            digit_q   <= '0;
                            state_q   <= ST_SCALE;
                        end
                    end
                end
                ST_SCALE: begin
                    if (scale_stop) begin
                        state_q <= ST_COUNT;
                    end else begin
                        scaled_q <= scale_y;
                        level_q  <= LVL_W'(level_q + 1'b1);
                    end
                end
                ST_COUNT: begin
                    if (fits) begin
                        part_q  <= diff;
                        digit_q <= DIG_W'(digit_q + 1'b1);
                    end else begin
                        quo_acc_q <= new_quo;
                        digit_q   <= '0;
                        if (level_q == '0) begin
                            quotient_o  <= new_quo[DATA_W-1:0];
                            remainder_o <= part_q[DATA_W-1:0];
                            div_zero_o  <= 1'b0;
                            done_o      <= 1'b1;
                            state_q     <= ST_IDLE;
                        end else begin
                            level_q  <= lad_rd_idx;
                            scaled_q <= lad_rd_val;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/decdiv_checker.sv
// Property checker for decdiv, attached by bind. It keeps its own copy of
// the accepted operands and checks the results against them.
module decdiv_checker #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy,
    input logic [DATA_W-1:0] dividend_i,
    input logic [DATA_W-1:0] divisor_i,
    input logic [DATA_W-1:0] quotient_o,
    input logic [DATA_W-1:0] remainder_o,
    input logic              done_o,
    input logic              div_zero_o
);
    logic [DATA_W-1:0] cap_a;
    logic [DATA_W-1:0] cap_b;

    // Record the operands of each accepted start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a <= '0;
            cap_b <= '0;
        end else if (start_i && !busy) begin
            cap_a <= dividend_i;
            cap_b <= divisor_i;
        end
    end

    a_r1_quot_rem_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_zero_o) |->
            (remainder_o < cap_b) &&
            (int'(quotient_o) * int'(cap_b) + int'(remainder_o) == int'(cap_a)));

    a_r3_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div_zero_o) |->
            (cap_b == '0) && (quotient_o == '0) && (remainder_o == cap_a));

    a_r4_small_dividend: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_b != '0 && cap_a < cap_b) |->
            (quotient_o == '0) && (remainder_o == cap_a) && !div_zero_o);

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));
endmodule

bind decdiv decdiv_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy       (busy),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .quotient_o (quotient_o),
    .remainder_o(remainder_o),
    .done_o     (done_o),
    .div_zero_o (div_zero_o)
);

// File: tb/decdiv_test.sv
`timescale 1ns/1ps
module decdiv_test;
    localparam int W  = 10;
    localparam int NV = 12;
    // Operand table: {dividend, divisor}
    localparam logic [2*W-1:0] VEC [NV] = '{
        {10'd128,  10'd4},   {10'd73,   10'd4},   {10'd1023, 10'd1},
        {10'd1000, 10'd1},   {10'd999,  10'd1},   {10'd5,    10'd5},
        {10'd1023, 10'd1023},{10'd500,  10'd7},   {10'd100,  10'd10},
        {10'd999,  10'd333}, {10'd1,    10'd1},   {10'd1023, 10'd2}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic [W-1:0] quotient_o;
    logic [W-1:0] remainder_o;
    logic         done_o;
    logic         div_zero_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    decdiv #(.DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .quotient_o(quotient_o), .remainder_o(remainder_o),
        .done_o(done_o), .div_zero_o(div_zero_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_latency(input int a, input int b);
        int k = 0; int s = b; int q = a / b; int ds = 0;
        while (s * 10 <= a) begin s = s * 10; k++; end
        while (q > 0) begin ds += q % 10; q = q / 10; end
        return 2 * k + 3 + ds;
    endfunction

    // Start one division and count edges until done, sampling at negedges.
    task automatic run_div(input int a, input int b, output int lat);
        @(negedge clk);
        dividend_i = W'(a); divisor_i = W'(b); start_i = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && lat < 200) begin
            @(posedge clk); lat++; @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R2: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int lat;
        int q0; int r0;
        // R8: reset state
        #1;
        check("R8 reset quotient", quotient_o, 0);
        check("R8 reset remainder", remainder_o, 0);
        check("R8 reset done", done_o, 0);
        check("R8 reset div_zero", div_zero_o, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1, R2, R5, R7: table walk
        for (int i = 0; i < NV; i++) begin
            int a; int b;
            a = int'(VEC[i][2*W-1:W]);
            b = int'(VEC[i][W-1:0]);
            run_div(a, b, lat);
            check($sformatf("R1 quotient %0d/%0d", a, b), quotient_o, a / b);
            check($sformatf("R1 remainder %0d/%0d", a, b), remainder_o, a % b);
            check($sformatf("R2 latency %0d/%0d", a, b), lat, exp_latency(a, b));
            check("R9 div_zero low", div_zero_o, 0);
            @(negedge clk);
            check("R5 done single cycle", done_o, 0);
            repeat (3) @(negedge clk);
            check("R7 quotient held", quotient_o, a / b);
            check("R7 remainder held", remainder_o, a % b);
        end

        // R2: the worked example, five subtractions
        run_div(128, 4, lat);
        check("R2 128/4 latency", lat, 10);

        // R3: zero divisor
        run_div(345, 0, lat);
        check("R3 div_zero set", div_zero_o, 1);
        check("R3 quotient", quotient_o, 0);
        check("R3 remainder", remainder_o, 345);
        check("R3 latency", lat, 1);
        @(negedge clk);
        check("R5 done after zero divisor", done_o, 0);
        check("R7 div_zero held", div_zero_o, 1);

        // R9: next valid division clears the flag
        run_div(50, 6, lat);
        check("R9 div_zero cleared", div_zero_o, 0);
        check("R9 quotient", quotient_o, 8);

        // R4: dividend below divisor
        run_div(17, 400, lat);
        check("R4 quotient", quotient_o, 0);
        check("R4 remainder", remainder_o, 17);
        check("R4 latency", lat, 1);
        check("R4 div_zero", div_zero_o, 0);

        // R6: start during a run is ignored
        @(negedge clk);
        dividend_i = 10'd128; divisor_i = 10'd4; start_i = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start_i = 1'b0;
        @(posedge clk); lat++; @(negedge clk);
        dividend_i = 10'd7; divisor_i = 10'd0; start_i = 1'b1;
        @(posedge clk); lat++; @(negedge clk);
        start_i = 1'b0;
        while (!done_o && lat < 200) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        check("R6 quotient unchanged", quotient_o, 32);
        check("R6 remainder unchanged", remainder_o, 0);
        check("R6 div_zero unchanged", div_zero_o, 0);
        check("R6 latency unchanged", lat, 10);

        // R8: asynchronous reset in the middle of a division
        run_div(900, 3, lat);
        q0 = quotient_o; r0 = remainder_o;
        check("R1 quotient 900/3", q0, 300);
        @(negedge clk);
        dividend_i = 10'd999; divisor_i = 10'd1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        check("R8 async quotient", quotient_o, 0);
        check("R8 async remainder", remainder_o, 0);
        check("R8 async done", done_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_div(81, 9, lat);
        check("R1 quotient after reset", quotient_o, 9);
        check("R2 latency after reset", lat, exp_latency(81, 9));

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule